// File: doc/BRIEF.md
# Reloading Down-Count Timer Channel

This block is one 32-bit timer channel with a small word-addressed register interface. A down-counter is clocked by a tick taken from the peripheral clock through a power-of-four prescaler. When a tick arrives with the counter at zero, the counter reloads from a constant register and a sticky underflow flag is set. The interrupt output is this flag gated by an enable bit in the control register. Software clears the flag by writing the control register with the flag bit at zero.

The enclosing unit runs or halts the count through `start_i`. Software reads registers combinationally in the same cycle as the request and writes them at the clock edge. Two control fields, one for an external clock edge and one for input capture, are stored and read back but have no effect. The capture register is a plain storage word when the `HAS_CAPT` parameter is 1.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload register and the counter read 0xFFFFFFFF, the control register and the capture register read 0, and `irq_o` is 0.
- R2: The word index `addr_i` selects a register: 0 is the reload constant, 1 is the counter, 2 is control, 3 is capture. A write stores `wdata_i` at the clock edge, and a read (`req_i`=1, `we_i`=0) returns the value on `rdata_o` in the same cycle. `rdata_o` is 0 when no read is requested.
- R3: Control bits 2:0 choose the prescaler code. Codes 0 to 4 give one tick every 4, 16, 64, 256 or 1024 started cycles. The first tick comes on the 4^(code+1)-th cycle after `start_i` rises, because the prescaler restarts whenever `start_i` is low. Each tick with the counter nonzero lowers it by one.
- R4: A tick with the counter at 0 loads the reload value into the counter and sets the underflow flag, which reads at control bit 8.
- R5: Prescaler codes 5, 6 and 7 make no tick, so the counter holds its value.
- R6: While `start_i` is low the counter holds its value and the underflow flag is never set.
- R7: A counter write in the same cycle as a tick wins. The counter takes the written value, and that tick neither lowers it nor sets the flag.
- R8: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: A control read returns the stored bits 7:0 and 15:10, the live flag at bit 8, and 0 at bit 9 and at bits 31:16. Bit 9 is never stored.
- R10: `irq_o` is high exactly when the underflow flag is set and control bit 5 is 1.
- R11: Control bits 4:3 and 7:6 read back as written and do not change the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run (1) or halt (0) the count |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The bench sets a counter write on top of a prescaler tick. A design that lets the tick win would show a value one lower, or would raise the flag from a stale zero. It clears the flag with the start input low, then with the bit-8 write value at 1, then with that value at 0. This shows whether a write of 1 wrongly sets or keeps the flag. It runs the reserved codes and the divide-by-1024 code through a full underflow, where a wrong mask width ticks too early or never. A long random phase mixes start toggles with writes, and a per-cycle model catches any off-by-one in the prescaler phase after restarts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned PSC_W    = 3;
  localparam int unsigned NUM_DIV  = 5;
  localparam int unsigned IE_BIT   = 5;
  localparam int unsigned UF_BIT   = 8;
  localparam int unsigned CF_BIT   = 9;

  typedef enum logic [IDX_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;

  // flag and capture-flag positions are never stored
  localparam logic [CTRL_W-1:0] CTRL_KEEP = ~((CTRL_W'(1) << UF_BIT) | (CTRL_W'(1) << CF_BIT));
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned NUM_CODES = tmr_pkg::NUM_DIV,
  parameter int unsigned SEL_W     = tmr_pkg::PSC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = 2 * NUM_CODES;

  logic [PRE_W-1:0]     pre_q;
  logic [NUM_CODES-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // code g divides by 4^(g+1): all low 2g+2 bits set
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_hit
    assign hit[g] = &pre_q[2*g+1:0];
  end

  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (sel_i == SEL_W'(i)) tick_o = run_i & hit[i];
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = tmr_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  // a write suppresses the tick entirely
  assign uflow_o = tick_i & at_zero & ~ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (tick_i)  cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter bit HAS_CAPT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uflow_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] reload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic [DATA_W-1:0] capt;
  logic              wr_reload, wr_ctrl, wr_capt;
  logic [CTRL_W-1:0] ctrl_rd;

  assign wr_reload = wr_i && (idx_i == REG_RELOAD);
  assign wr_ctrl   = wr_i && (idx_i == REG_CTRL);
  assign wr_capt   = wr_i && (idx_i == REG_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata_i;
      if (wr_ctrl)   ctrl_q   <= wdata_i[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  // set beats clear; writing 1 never sets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           flag_q <= 1'b0;
    else if (uflow_i && start_i)           flag_q <= 1'b1;
    else if (wr_ctrl && !wdata_i[UF_BIT])  flag_q <= 1'b0;
  end

  if (HAS_CAPT) begin : g_capt
    logic [DATA_W-1:0] capt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      capt_q <= '0;
      else if (wr_capt) capt_q <= wdata_i;
    end
    assign capt = capt_q;
  end else begin : g_no_capt
    assign capt = '0;
  end

  always_comb begin
    ctrl_rd         = ctrl_q;
    ctrl_rd[UF_BIT] = flag_q;
  end

  always_comb begin
    unique case (idx_i)
      REG_RELOAD: rdata_o = reload_q;
      REG_COUNT:  rdata_o = cnt_i;
      REG_CTRL:   rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_rd};
      default:    rdata_o = capt;
    endcase
  end

  assign reload_o = reload_q;
  assign psc_o    = ctrl_q[PSC_W-1:0];
  assign ie_o     = ctrl_q[IE_BIT];
  assign flag_o   = flag_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter bit HAS_CAPT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              wr, cnt_wr, tick, uflow, ie, flag_q;
  logic [PSC_W-1:0]  psc;
  logic [DATA_W-1:0] cnt_q, reload_q, rd_mux;

  assign wr     = req_i & we_i;
  assign cnt_wr = wr && (addr_i == REG_COUNT);

  tmr_prescaler #(.NUM_CODES(NUM_DIV), .SEL_W(PSC_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (start_i),
    .sel_i  (psc),
    .tick_o (tick)
  );

  tmr_counter #(.W(DATA_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_wr),
    .ld_val_i (wdata_i),
    .tick_i   (tick),
    .reload_i (reload_q),
    .cnt_o    (cnt_q),
    .uflow_o  (uflow)
  );

  tmr_regs #(.HAS_CAPT(HAS_CAPT)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .idx_i    (addr_i),
    .wdata_i  (wdata_i),
    .uflow_i  (uflow),
    .start_i  (start_i),
    .cnt_i    (cnt_q),
    .reload_o (reload_q),
    .psc_o    (psc),
    .ie_o     (ie),
    .flag_o   (flag_q),
    .rdata_o  (rd_mux)
  );

  assign rdata_o = (req_i && !we_i) ? rd_mux : '0;
  assign irq_o   = flag_q & ie;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic        tick_i,
  input logic [2:0]  psc_i,
  input logic [31:0] cnt_i,
  input logic [31:0] reload_i,
  input logic        flag_i
);
  logic cnt_wr, ctrl_clr;
  assign cnt_wr   = req_i && we_i && (addr_i == 2'd1);
  assign ctrl_clr = req_i && we_i && (addr_i == 2'd2) && !wdata_i[8];

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr && cnt_i != 32'd0 |=> cnt_i == $past(cnt_i) - 32'd1);

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr && cnt_i == 32'd0 |=> cnt_i == $past(reload_i) && flag_i);

  a_r5_reserved_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_i > 3'd4 |-> !tick_i);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !cnt_wr |=> $stable(cnt_i));

  a_r6_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !flag_i |=> !flag_i);

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_i == $past(wdata_i));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_clr && !(tick_i && cnt_i == 32'd0 && !cnt_wr) |=> !flag_i);

  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_i);
endmodule

bind tmr_channel tmr_channel_chk i_tmr_channel_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .tick_i   (tick),
  .psc_i    (psc),
  .cnt_i    (cnt_q),
  .reload_i (reload_q),
  .flag_i   (flag_q)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  idx = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_cnt, m_reload, m_ctrl, m_capt;
  logic        m_flag;
  int          m_pre;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req), .we_i(we),
    .addr_i(idx), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return m_reload;
      2'd1: return m_cnt;
      2'd2: return m_ctrl | (m_flag ? 32'h100 : 32'h0);
      default: return m_capt;
    endcase
  endfunction

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '1; m_reload = '1; m_ctrl = '0; m_capt = '0; m_flag = 1'b0; m_pre = 0;
  endtask

  task automatic model_step();
    logic        wr, tk, uf;
    int          code, dv;
    logic [31:0] ncnt;
    wr   = req && we;
    code = int'(m_ctrl[2:0]);
    dv   = 4 << (2 * code);
    tk   = start && code <= 4 && (m_pre % dv == dv - 1);
    uf   = tk && m_cnt == 0 && !(wr && idx == 2'd1);
    if (wr && idx == 2'd1) ncnt = wdata;
    else if (tk)           ncnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
    else                   ncnt = m_cnt;
    if (uf) m_flag = 1'b1;
    else if (wr && idx == 2'd2 && !wdata[8]) m_flag = 1'b0;
    if (wr && idx == 2'd0) m_reload = wdata;
    if (wr && idx == 2'd2) m_ctrl = wdata & 32'h0000_FCFF;
    if (wr && idx == 2'd3) m_capt = wdata;
    m_cnt = ncnt;
    m_pre = start ? (m_pre + 1) % 1024 : 0;
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    if (req && !we) expect32(idx == 2'd2 ? "R9 ctrl" : "R3 model", rdata, mread(idx));
    expect32("R10 irq", {31'b0, irq}, {31'b0, m_flag & m_ctrl[5]});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; idx = a; wdata = d;
    cyc();
    we = 1'b0; idx = 2'd1;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    idx = a; we = 1'b0; req = 1'b1;
    #1 expect32(tag, rdata, exp);
    idx = 2'd1;
  endtask

  initial begin
    model_reset();
    run(3);
    rst_n = 1'b1;
    run(1);
    // R1 reset values
    rd_chk("R1 reload", 2'd0, 32'hFFFF_FFFF);
    rd_chk("R1 count", 2'd1, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl", 2'd2, 32'h0);
    rd_chk("R1 capt", 2'd3, 32'h0);
    expect32("R1 irq", {31'b0, irq}, 32'h0);
    // R2 register map
    wr_reg(2'd0, 32'h5);
    wr_reg(2'd3, 32'hA5A5_1234);
    rd_chk("R2 reload", 2'd0, 32'h5);
    rd_chk("R2 capt", 2'd3, 32'hA5A5_1234);
    req = 1'b0; #1 expect32("R2 idle zero", rdata, 32'h0); req = 1'b1;
    // R9 / R11 readback of all fields, bit 9 dropped
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_chk("R9 ctrl mask", 2'd2, 32'h0000_FCFF);
    // R5 reserved code 7: no counting
    wr_reg(2'd1, 32'd10);
    start = 1'b1;
    run(50);
    rd_chk("R5 hold", 2'd1, 32'd10);
    // R3 / R4 code 0 with edge and capture fields set (R11)
    start = 1'b0;
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd2, 32'h0000_00F8);
    start = 1'b1;
    run(4);
    rd_chk("R3 first tick", 2'd1, 32'd1);
    run(4);
    rd_chk("R3 second tick", 2'd1, 32'd0);
    run(4);
    rd_chk("R4 reload", 2'd1, 32'd5);
    rd_chk("R4 flag", 2'd2, 32'h0000_01F8);
    expect32("R10 irq on", {31'b0, irq}, 32'h1);
    // R8 flag clear rules
    start = 1'b0;
    wr_reg(2'd2, 32'h0000_0120);
    rd_chk("R8 write one keeps", 2'd2, 32'h0000_0120);
    wr_reg(2'd2, 32'h0000_0100);
    expect32("R10 irq masked", {31'b0, irq}, 32'h0);
    rd_chk("R8 flag still set", 2'd2, 32'h0000_0100);
    wr_reg(2'd2, 32'h0000_0020);
    rd_chk("R8 cleared", 2'd2, 32'h0000_0020);
    // R6 halted
    run(30);
    rd_chk("R6 hold", 2'd1, 32'd5);
    // R7 write vs tick
    start = 1'b1;
    for (int i = 0; i < 8; i++) wr_reg(2'd1, 32'd100);
    rd_chk("R7 write wins", 2'd1, 32'd100);
    // R3 code 1
    start = 1'b0;
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd2, 32'h0000_0021);
    start = 1'b1;
    run(15);
    rd_chk("R3 div16 early", 2'd1, 32'd3);
    run(1);
    rd_chk("R3 div16", 2'd1, 32'd2);
    // R4 code 4
    start = 1'b0;
    wr_reg(2'd0, 32'd7);
    wr_reg(2'd1, 32'd1);
    wr_reg(2'd2, 32'h0000_0024);
    start = 1'b1;
    run(2048);
    rd_chk("R4 div1024 reload", 2'd1, 32'd7);
    expect32("R10 irq div1024", {31'b0, irq}, 32'h1);
    // random mix, model compared every cycle
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 31) == 0) start = ~start;
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] a;
        logic [31:0] d;
        a = 2'($urandom_range(0, 3));
        d = $urandom;
        if (a != 2'd3) d = d & (a == 2'd2 ? 32'h0000_FF23 : 32'h0000_001F);
        if (a == 2'd2 && d[2:0] == 3'd4) d[2:0] = 3'd0;
        wr_reg(a, d);
      end else begin
        idx = 2'($urandom_range(0, 3));
        cyc();
        idx = 2'd1;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule